// File: doc/BRIEF.md
# Level-Encoded Dual-Rail Word Serializer

This block takes a parallel data word and sends it out bit by bit as a level-encoded dual-rail stream. The stream uses a state line and a phase line, and each of them has a complementary wire. The state line carries the data bit itself. The phase line is computed so that, from one bit to the next, exactly one of the two lines toggles. A receiver can therefore recover timing from the wires alone.

Bits leave the block least significant first. One bit goes out for every change on a control input, whether that change is a rise or a fall. The word is encoded once when it is accepted: the state and phase sequences and their complements are loaded in parallel into four shift lanes, one per output wire.

There is no per-bit handshake. The sender loads a word and toggles the control line once per bit. It then waits for a single acknowledge for the whole word before the block takes the next one. After reset, the first word's leading phase bit comes from an input. Every later word continues from the levels already on the wires, so a word boundary costs no extra toggles.

Top module: `lvlphase_ser`

## Requirements
- R1: The state output carries the word's data bits, bit 0 first, one new bit per detected control change. When the control input changes between clock edge k-1 and clock edge k, the outputs take the next bit's levels at clock edge k.
- R2: Within a word, the phase of bit i+1 is the inverse of the phase of bit i when their data bits are equal, and the same as the phase of bit i otherwise.
- R3: After reset the outputs are: state 0, phase 0, both complement outputs 1, busy 0. In the first word after reset, bit 0 is sent with phase equal to the `phase_init_i` value sampled at the accepted load.
- R4: `s_n_o` is always the inverse of `s_o`, and `p_n_o` is always the inverse of `p_o`.
- R5: Rising and falling changes of `xfer_i` each shift exactly one bit. While `xfer_i` holds its level, the outputs hold theirs, including in the cycle right after a load.
- R6: For every bit except bit 0 of the first word after reset, exactly one of the state and phase outputs toggles. This includes the first bit of each later word, whose phase is chosen from the levels left on the wires.
- R7: A load in idle is accepted, and `busy_o` goes high on the next clock edge. Busy stays high through all W bits and until the acknowledge. A load while busy is ignored and does not change the data that is sent.
- R8: An acknowledge while bits remain to be sent is ignored. An acknowledge after the last bit clears `busy_o` at the next clock edge. Control changes while all bits are out, or while idle, leave the outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| word_i | input | W | Parallel data word |
| load_i | input | 1 | Load strobe; accepted only when idle |
| phase_init_i | input | 1 | Leading phase bit for the first word after reset |
| xfer_i | input | 1 | Control line; each level change sends one bit |
| ack_i | input | 1 | Word-level acknowledge |
| s_o | output | 1 | State line |
| s_n_o | output | 1 | Complement of the state line |
| p_o | output | 1 | Phase line |
| p_n_o | output | 1 | Complement of the phase line |
| busy_o | output | 1 | High from an accepted load until the acknowledge |

## Verification
The hardest case to reach from the ports is the boundary between two words. Here the leading phase of the new word must be chosen from the levels the previous word left on the wires. A single-toggle violation at that point only appears for particular pairs of a last bit and a next first bit. The stimulus uses a 4-bit word and sends every word value back to back without resetting in between. Since word v is always followed by v+1, every combination of previous last bit and next first bit is crossed with a carried phase of either value. The sweep is repeated for both initial phase values. Early acknowledges, loads while busy, idle gaps, and control changes after the last bit are mixed into every word.

// File: rtl/lvlphase_pkg.sv
package lvlphase_pkg;
   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_SHIFT = 2'd1,
      PH_WAIT  = 2'd2
   } ph_state_e;

   localparam int LANES = 4;
   // lane order: state, state complement, phase, phase complement
   localparam int LANE_S  = 0;
   localparam int LANE_SN = 1;
   localparam int LANE_P  = 2;
   localparam int LANE_PN = 3;
endpackage

// File: rtl/lvlphase_encoder.sv
module lvlphase_encoder #(
   parameter int W         = 16,
   parameter bit RIPPLE    = 1'b0
) (
   input  logic [W-1:0] data_i,
   input  logic         phase0_i,
   output logic [W-1:0] st_o,
   output logic [W-1:0] ph_o
);
   assign st_o = data_i;

   generate
      if (RIPPLE) begin : g_ripple
         // phase chain: toggle on repeated data, hold on a data change
         assign ph_o[0] = phase0_i;
         for (genvar i = 1; i < W; i++) begin : g_bit
            assign ph_o[i] = (data_i[i] == data_i[i-1]) ? ~ph_o[i-1] : ph_o[i-1];
         end
      end else begin : g_parity
         // closed form: state xor phase alternates every bit
         for (genvar i = 0; i < W; i++) begin : g_bit
            localparam bit ODD = (i % 2) == 1;
            assign ph_o[i] = data_i[i] ^ data_i[0] ^ phase0_i ^ ODD;
         end
      end
   endgenerate
endmodule

// File: rtl/lvlphase_lane.sv
module lvlphase_lane #(
   parameter int W       = 16,
   parameter bit RST_LVL = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load_i,
   input  logic         shift_i,
   input  logic [W-1:0] din_i,
   output logic         line_o
);
   logic [W-1:0] sr_q;
   logic         line_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sr_q   <= '0;
         line_q <= RST_LVL;
      end else if (load_i) begin
         sr_q   <= din_i;
      end else if (shift_i) begin
         line_q <= sr_q[0];
         sr_q   <= {1'b0, sr_q[W-1:1]};
      end
   end

   assign line_o = line_q;
endmodule

// File: rtl/lvlphase_ctrl.sv
module lvlphase_ctrl
   import lvlphase_pkg::*;
#(
   parameter int W = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load_i,
   input  logic xfer_i,
   input  logic ack_i,
   output logic load_go_o,
   output logic shift_go_o,
   output logic busy_o,
   output logic seeded_o
);
   localparam int CNT_W = (W > 1) ? $clog2(W) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(W - 1);

   ph_state_e        st_q;
   logic [CNT_W-1:0] cnt_q;
   logic             xfer_q;
   logic             seeded_q;
   logic             edge_seen;

   assign edge_seen  = xfer_i ^ xfer_q;
   assign load_go_o  = (st_q == PH_IDLE) && load_i;
   assign shift_go_o = (st_q == PH_SHIFT) && edge_seen;
   assign busy_o     = (st_q != PH_IDLE);
   assign seeded_o   = seeded_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         xfer_q <= 1'b0;
      end else begin
         xfer_q <= xfer_i;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q     <= PH_IDLE;
         cnt_q    <= '0;
         seeded_q <= 1'b0;
      end else begin
         unique case (st_q)
            PH_IDLE: begin
               if (load_i) begin
                  st_q     <= PH_SHIFT;
                  cnt_q    <= '0;
                  seeded_q <= 1'b1;
               end
            end
            PH_SHIFT: begin
               if (edge_seen) begin
                  if (cnt_q == LAST) begin
                     st_q <= PH_WAIT;
                  end
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            PH_WAIT: begin
               if (ack_i) begin
                  st_q <= PH_IDLE;
               end
            end
            default: st_q <= PH_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/lvlphase_ser.sv
module lvlphase_ser
   import lvlphase_pkg::*;
#(
   parameter int W          = 16,
   parameter bit ENC_RIPPLE = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] word_i,
   input  logic         load_i,
   input  logic         phase_init_i,
   input  logic         xfer_i,
   input  logic         ack_i,
   output logic         s_o,
   output logic         s_n_o,
   output logic         p_o,
   output logic         p_n_o,
   output logic         busy_o
);
   generate
      if (W < 2) begin : g_bad_w
         $error("lvlphase_ser: W must be at least 2");
      end
   endgenerate

   logic                    load_go;
   logic                    shift_go;
   logic                    seeded;
   logic                    phase0;
   logic [W-1:0]            enc_st;
   logic [W-1:0]            enc_ph;
   logic [LANES-1:0][W-1:0] lane_din;
   logic [LANES-1:0]        lane_line;

   lvlphase_ctrl #(.W(W)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (load_i),
      .xfer_i     (xfer_i),
      .ack_i      (ack_i),
      .load_go_o  (load_go),
      .shift_go_o (shift_go),
      .busy_o     (busy_o),
      .seeded_o   (seeded)
   );

   // leading phase: seeded from input after reset, else continue from wires
   always_comb begin
      if (!seeded) begin
         phase0 = phase_init_i;
      end else if (word_i[0] == lane_line[LANE_S]) begin
         phase0 = ~lane_line[LANE_P];
      end else begin
         phase0 = lane_line[LANE_P];
      end
   end

   lvlphase_encoder #(.W(W), .RIPPLE(ENC_RIPPLE)) u_enc (
      .data_i   (word_i),
      .phase0_i (phase0),
      .st_o     (enc_st),
      .ph_o     (enc_ph)
   );

   assign lane_din[LANE_S]  = enc_st;
   assign lane_din[LANE_SN] = ~enc_st;
   assign lane_din[LANE_P]  = enc_ph;
   assign lane_din[LANE_PN] = ~enc_ph;

   generate
      for (genvar k = 0; k < LANES; k++) begin : g_lane
         localparam bit RST_LVL = (k % 2) == 1;
         lvlphase_lane #(.W(W), .RST_LVL(RST_LVL)) u_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .load_i  (load_go),
            .shift_i (shift_go),
            .din_i   (lane_din[k]),
            .line_o  (lane_line[k])
         );
      end
   endgenerate

   assign s_o   = lane_line[LANE_S];
   assign s_n_o = lane_line[LANE_SN];
   assign p_o   = lane_line[LANE_P];
   assign p_n_o = lane_line[LANE_PN];
endmodule

// File: rtl/lvlphase_chk.sv
module lvlphase_chk (
   input logic clk,
   input logic rst_n,
   input logic load_i,
   input logic xfer_i,
   input logic ack_i,
   input logic s_o,
   input logic s_n_o,
   input logic p_o,
   input logic p_n_o,
   input logic busy_o
);
   logic busy_d;
   logic word_done;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_d    <= 1'b0;
         word_done <= 1'b0;
      end else begin
         busy_d <= busy_o;
         if (busy_d && !busy_o) begin
            word_done <= 1'b1;
         end
      end
   end

   // R4
   comp_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (s_n_o == ~s_o) && (p_n_o == ~p_o));

   // R5
   hold_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $stable(xfer_i) |=> ($stable(s_o) && $stable(p_o)));

   // R8
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((s_o != $past(s_o)) || (p_o != $past(p_o))) |-> $past(busy_o));

   // R6
   single_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      word_done |-> !((s_o != $past(s_o)) && (p_o != $past(p_o))));

   // R7
   busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> $past(load_i));

   // R8
   busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> $past(ack_i));
endmodule

bind lvlphase_ser lvlphase_chk u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .load_i (load_i),
   .xfer_i (xfer_i),
   .ack_i  (ack_i),
   .s_o    (s_o),
   .s_n_o  (s_n_o),
   .p_o    (p_o),
   .p_n_o  (p_n_o),
   .busy_o (busy_o)
);

// File: tb/tb_lvlphase_ser.sv
`timescale 1ns/1ps
module tb_lvlphase_ser;
   localparam int W = 4;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [W-1:0] word_i = '0;
   logic         load_i = 1'b0;
   logic         phase_init_i = 1'b0;
   logic         xfer_i = 1'b0;
   logic         ack_i = 1'b0;
   logic         s_o, s_n_o, p_o, p_n_o, busy_o;

   int  total = 0;
   int  bad = 0;
   bit  exp_s, exp_p;
   bit  first_word;

   always #2 clk = ~clk;

   lvlphase_ser #(.W(W)) dut (
      .clk(clk), .rst_n(rst_n), .word_i(word_i), .load_i(load_i),
      .phase_init_i(phase_init_i), .xfer_i(xfer_i), .ack_i(ack_i),
      .s_o(s_o), .s_n_o(s_n_o), .p_o(p_o), .p_n_o(p_n_o), .busy_o(busy_o)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic chk_lines(input string req);
      chk(s_o == exp_s, req, s_o, exp_s);
      chk(p_o == exp_p, req, p_o, exp_p);
      chk(s_n_o == !exp_s, {req, " R4 s_n"}, s_n_o, !exp_s);
      chk(p_n_o == !exp_p, {req, " R4 p_n"}, p_n_o, !exp_p);
   endtask

   task automatic do_reset(input bit init);
      rst_n = 1'b0; load_i = 0; ack_i = 0; xfer_i = 0; phase_init_i = init;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      exp_s = 0; exp_p = 0; first_word = 1;
      // R3 reset state
      chk_lines("R3 reset");
      chk(busy_o == 0, "R3 busy reset", busy_o, 0);
   endtask

   task automatic send_word(input logic [W-1:0] w);
      bit nxt_p, old_s, old_p;
      load_i = 1; word_i = w;
      @(negedge clk);
      load_i = 0; word_i = ~w;
      chk(busy_o == 1, "R7 busy after load", busy_o, 1);
      chk_lines("R5 no shift on load");
      for (int i = 0; i < W; i++) begin
         if (i == 1) begin
            ack_i = 1; load_i = 1;
            @(negedge clk);
            ack_i = 0; load_i = 0;
            chk(busy_o == 1, "R8 early ack ignored", busy_o, 1);
            chk_lines("R7 load while busy");
         end
         if (i % 2 == 1) begin
            repeat (2) @(negedge clk);
            chk_lines("R5 hold while stable");
         end
         if (first_word && i == 0) nxt_p = phase_init_i;
         else if (w[i] == exp_s) nxt_p = !exp_p;
         else nxt_p = exp_p;
         old_s = exp_s; old_p = exp_p;
         exp_s = w[i]; exp_p = nxt_p;
         xfer_i = ~xfer_i;
         @(negedge clk);
         chk_lines((i == 0) ? "R1 R2 R3 first bit" : "R1 R2 R5 bit");
         if (!(first_word && i == 0))
            chk(((s_o != old_s) + (p_o != old_p)) == 1, "R6 one toggle",
                (s_o != old_s) + (p_o != old_p), 1);
      end
      chk(busy_o == 1, "R7 busy until ack", busy_o, 1);
      xfer_i = ~xfer_i;
      @(negedge clk);
      chk_lines("R8 extra edge ignored");
      ack_i = 1;
      @(negedge clk);
      ack_i = 0;
      chk(busy_o == 0, "R8 ack clears busy", busy_o, 0);
      xfer_i = ~xfer_i;
      @(negedge clk);
      chk_lines("R8 idle edge ignored");
      first_word = 0;
   endtask

   initial begin
      for (int init = 0; init < 2; init++) begin
         do_reset(init[0]);
         for (int v = 0; v < (1 << W); v++) begin
            send_word(v[W-1:0]);
         end
      end
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(4 * 150000);
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule